// File: doc/BRIEF.md
# Masked Interrupt Request Aggregator

This block collects one-cycle event pulses from a set of sources into a request register. It raises a single active-low interrupt line whenever at least one pending request is not masked. A host controls it through a small synchronous register port: it reads the raw requests, programs a mask, acknowledges requests through a clear register, and sets enable bits for three error sources. The interrupt line drives an open-drain pad, so the block outputs both the active-low level and a pad output-enable that is high while the line is pulled low.

Writing to the clear register works by inversion: a bit written as zero acknowledges the matching request, and a bit written as one leaves it alone. Reset masks every source and turns off all three error sources. The host must therefore unmask sources and enable the error sources before any interrupt can appear. The lowest three sources are the error sources: bit 0 is transmit error, bit 1 is PLL error and bit 2 is receive error. The other sources are always live.

Top module: `irq_aggregator`

## Requirements
- R1: While `rst` is high and at the first edge after it, the request register becomes 0x00, the mask register 0xFF and the error-enable bits 0. `irq_n` is then 1 and `irq_oe` is 0.
- R2: A one-cycle pulse on `evt_i[i]` for a source i of 3 or higher sets request bit i at the next rising clock edge. The bit stays set until it is cleared.
- R3: Sources 0 (transmit error), 1 (PLL error) and 2 (receive error) set their request bit only when the matching error-enable bit is 1. The error-enable bits are bits [2:0] of the register at address 3.
- R4: A write to address 2 clears each request bit whose data bit is 0. Request bits whose data bit is 1 are left unchanged.
- R5: When an event and a clear for the same bit fall in the same cycle, the event wins and the request bit ends up set.
- R6: `irq_oe` is 1 and `irq_n` is 0 exactly when (request AND NOT mask) is nonzero. Both follow the registered state with no added delay.
- R7: The interrupt stays asserted while any unmasked request remains pending, even after other requests have been cleared.
- R8: Reads are combinational from `reg_addr`. Address 0 returns the raw request bits whatever the mask holds. Address 1 returns the mask, address 3 returns the error-enable bits zero-extended, and address 2 returns 0xFF.
- R9: A write to address 0 leaves the request register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 8 | One-cycle event pulses, one per source |
| reg_addr | input | 2 | Register select: 0 request, 1 mask, 2 clear, 3 error enable |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| irq_n | output | 1 | Active-low interrupt level |
| irq_oe | output | 1 | Pad output-enable, high while the line is pulled low |

## Verification
The hardest case to reach from the ports is an event landing in the same cycle as a clear-register write that acknowledges that same bit. Close behind it is an error event arriving just as its enable bit changes. The bench drives event pulses and register writes from one step task, so it can put an event and a clear in the same clock cycle on purpose. It then runs a long random sequence that mixes events, mask writes, enable writes and partial clears, and compares each cycle against a request-and-not-mask reference model. An exhaustive sweep over all 256 clear patterns covers the write-zero-to-clear rule bit by bit.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_REQ   = 2'd0,
        SEL_MASK  = 2'd1,
        SEL_CLR   = 2'd2,
        SEL_ERREN = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic mask_we;
        logic clr_we;
        logic erren_we;
    } wr_strobe_t;

    function automatic wr_strobe_t decode_wr(input logic we, input reg_sel_e sel);
        wr_strobe_t s;
        s.mask_we  = we && (sel == SEL_MASK);
        s.clr_we   = we && (sel == SEL_CLR);
        s.erren_we = we && (sel == SEL_ERREN);
        return s;
    endfunction

endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
    import irq_agg_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int NUM_ERR = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  wr_strobe_t         strb,
    input  logic [NUM_SRC-1:0] wdata,
    output logic [NUM_SRC-1:0] mask_q,
    output logic [NUM_ERR-1:0] erren_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q  <= '1;
            erren_q <= '0;
        end else begin
            if (strb.mask_we)  mask_q  <= wdata;
            if (strb.erren_we) erren_q <= wdata[NUM_ERR-1:0];
        end
    end

endmodule

// File: rtl/irq_req_bank.sv
module irq_req_bank #(
    parameter int NUM_SRC = 8,
    parameter int NUM_ERR = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic [NUM_ERR-1:0] erren,
    input  logic               clr_we,
    input  logic [NUM_SRC-1:0] clr_data,
    output logic [NUM_SRC-1:0] req_q
);

    logic [NUM_SRC-1:0] set_vec;
    logic [NUM_SRC-1:0] drop_vec;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        if (i < NUM_ERR) begin : g_gated
            assign set_vec[i] = evt_i[i] & erren[i];
        end else begin : g_live
            assign set_vec[i] = evt_i[i];
        end
    end

    // zero in clear data acknowledges; one is a no-op
    assign drop_vec = clr_we ? ~clr_data : '0;

    always_ff @(posedge clk) begin
        if (rst) req_q <= '0;
        else     req_q <= (req_q & ~drop_vec) | set_vec;   // set wins
    end

endmodule

// File: rtl/irq_pad_drv.sv
module irq_pad_drv #(
    parameter int NUM_SRC = 8
) (
    input  logic [NUM_SRC-1:0] req,
    input  logic [NUM_SRC-1:0] mask,
    output logic               irq_oe,
    output logic               irq_n
);

    logic [NUM_SRC-1:0] live;

    assign live   = req & ~mask;
    assign irq_oe = |live;
    assign irq_n  = ~irq_oe;

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int NUM_ERR = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic               reg_wr,
    input  logic [NUM_SRC-1:0] reg_wdata,
    output logic [NUM_SRC-1:0] reg_rdata,
    output logic               irq_n,
    output logic               irq_oe
);

    reg_sel_e           sel;
    wr_strobe_t         strb;
    logic [NUM_SRC-1:0] req_q;
    logic [NUM_SRC-1:0] mask_q;
    logic [NUM_ERR-1:0] erren_q;

    assign sel  = reg_sel_e'(reg_addr);
    assign strb = decode_wr(reg_wr, sel);

    irq_cfg_regs #(.NUM_SRC(NUM_SRC), .NUM_ERR(NUM_ERR)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .strb    (strb),
        .wdata   (reg_wdata),
        .mask_q  (mask_q),
        .erren_q (erren_q)
    );

    irq_req_bank #(.NUM_SRC(NUM_SRC), .NUM_ERR(NUM_ERR)) u_req (
        .clk      (clk),
        .rst      (rst),
        .evt_i    (evt_i),
        .erren    (erren_q),
        .clr_we   (strb.clr_we),
        .clr_data (reg_wdata),
        .req_q    (req_q)
    );

    irq_pad_drv #(.NUM_SRC(NUM_SRC)) u_pad (
        .req    (req_q),
        .mask   (mask_q),
        .irq_oe (irq_oe),
        .irq_n  (irq_n)
    );

    always_comb begin
        unique case (sel)
            SEL_REQ:   reg_rdata = req_q;
            SEL_MASK:  reg_rdata = mask_q;
            SEL_CLR:   reg_rdata = '1;
            SEL_ERREN: reg_rdata = {{(NUM_SRC-NUM_ERR){1'b0}}, erren_q};
            default:   reg_rdata = '1;
        endcase
    end

endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk #(
    parameter int NUM_SRC = 8,
    parameter int NUM_ERR = 3
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_SRC-1:0] evt_i,
    input logic [1:0]         reg_addr,
    input logic               reg_wr,
    input logic [NUM_SRC-1:0] reg_wdata,
    input logic [NUM_SRC-1:0] req_q,
    input logic [NUM_SRC-1:0] mask_q,
    input logic [NUM_ERR-1:0] erren_q,
    input logic               irq_n,
    input logic               irq_oe
);

    localparam logic [NUM_SRC-1:0] ERR_BITS = NUM_SRC'((1 << NUM_ERR) - 1);

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (mask_q == '1 && erren_q == '0 && req_q == '0));          // R1

    AST_LIVE_SETS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((($past(evt_i) & ~ERR_BITS) & ~req_q) == '0));          // R2

    AST_ERR_GATED: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (((req_q & ~$past(req_q) & ERR_BITS) &
                   ~NUM_SRC'($past(erren_q))) == '0));                    // R3

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 2'd2) |=>
            ((req_q & ~$past(reg_wdata) & ~$past(evt_i)) == '0));          // R4

    AST_CLEAR_ONE_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 2'd2) |=>
            (($past(req_q) & $past(reg_wdata) & ~req_q) == '0));           // R4

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 2'd2) |=>
            ((($past(evt_i) & ~ERR_BITS) & ~req_q) == '0));                // R5

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((req_q & ~$past(req_q) & ~$past(evt_i)) == '0));        // R2

    AST_LINE_MATCH: assert property (@(posedge clk) disable iff (rst)
        irq_oe == (|(req_q & ~mask_q)));                                   // R6

    AST_LINE_POLARITY: assert property (@(posedge clk) disable iff (rst)
        irq_n != irq_oe);                                                  // R6

    AST_REQ_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 2'd0 && evt_i == '0) |=>
            (req_q == $past(req_q)));                                      // R9

endmodule

bind irq_aggregator irq_aggregator_chk #(.NUM_SRC(NUM_SRC), .NUM_ERR(NUM_ERR)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .evt_i     (evt_i),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .req_q     (req_q),
    .mask_q    (mask_q),
    .erren_q   (erren_q),
    .irq_n     (irq_n),
    .irq_oe    (irq_oe)
);

// File: tb/tb_irq_aggregator.sv
`timescale 1ns/1ps
module tb_irq_aggregator;

    localparam int N = 8;
    localparam int NE = 3;
    localparam logic [N-1:0] ERRB = 8'h07;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] evt_i = '0;
    logic [1:0]   reg_addr = 2'd0;
    logic         reg_wr = 1'b0;
    logic [N-1:0] reg_wdata = '0;
    logic [N-1:0] reg_rdata;
    logic         irq_n;
    logic         irq_oe;

    int n_chk = 0;
    int n_fail = 0;

    logic [N-1:0]  req_m  = '0;
    logic [N-1:0]  mask_m = '1;
    logic [NE-1:0] en_m   = '0;

    always #10 clk = ~clk;   // 50 MHz

    irq_aggregator #(.NUM_SRC(N), .NUM_ERR(NE)) dut (
        .clk(clk), .rst(rst), .evt_i(evt_i), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_n(irq_n), .irq_oe(irq_oe)
    );

    task automatic check(input string tag, input logic [N-1:0] got, input logic [N-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic step(input logic [N-1:0] ev, input logic wr,
                        input logic [1:0] a, input logic [N-1:0] d);
        logic [N-1:0] drop;
        @(negedge clk);
        evt_i = ev; reg_wr = wr; reg_addr = a; reg_wdata = d;
        drop = (wr && a == 2'd2) ? ~d : '0;
        req_m = (req_m & ~drop) | (ev & ({{(N-NE){1'b1}}, en_m}));
        if (wr && a == 2'd1) mask_m = d;
        if (wr && a == 2'd3) en_m = d[NE-1:0];
        @(posedge clk);
        #1;
        evt_i = '0; reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [N-1:0] v);
        @(negedge clk);
        reg_addr = a; reg_wr = 1'b0; evt_i = '0;
        #1 v = reg_rdata;
    endtask

    task automatic check_line(input string tag);
        logic exp_oe;
        exp_oe = |(req_m & ~mask_m);
        check(tag, {7'd0, irq_oe}, {7'd0, exp_oe});
        check(tag, {7'd0, irq_n}, {7'd0, ~exp_oe});
    endtask

    task automatic check_req(input string tag);
        logic [N-1:0] v;
        rd(2'd0, v);
        check(tag, v, req_m);
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1;
        @(negedge clk); rst = 1'b0;
        req_m = '0; mask_m = '1; en_m = '0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [N-1:0] v;
        repeat (3) @(posedge clk);
        do_reset();

        // R1 reset state
        rd(2'd1, v); check("R1 mask", v, 8'hFF);
        rd(2'd3, v); check("R1 erren", v, 8'h00);
        rd(2'd0, v); check("R1 req", v, 8'h00);
        check("R1 irq_n", {7'd0, irq_n}, 8'h01);
        check("R1 irq_oe", {7'd0, irq_oe}, 8'h00);
        rd(2'd2, v); check("R8 clr read", v, 8'hFF);

        // R2 / R3: each source alone with error sources disabled
        for (int i = 0; i < N; i++) begin
            step(8'(1 << i), 1'b0, 2'd0, '0);
            check_req((i < NE) ? "R3 gated off" : "R2 live set");
        end
        check_req("R2 sticky");
        check_line("R6 masked");

        // R9 write to request address ignored
        step('0, 1'b1, 2'd0, 8'h00);
        check_req("R9 req write");

        // R3 enable error sources one at a time
        for (int i = 0; i < NE; i++) begin
            step('0, 1'b1, 2'd3, 8'(1 << i));
            step(ERRB, 1'b0, 2'd0, '0);
            check_req("R3 gated on");
            rd(2'd3, v); check("R8 erren read", v, 8'(1 << i));
        end

        // R4 / R6 exhaustive clear patterns
        step('0, 1'b1, 2'd3, 8'h07);
        step('0, 1'b1, 2'd1, 8'h00);
        for (int c = 0; c < 256; c++) begin
            step(8'hFF, 1'b0, 2'd0, '0);
            step('0, 1'b1, 2'd2, 8'(c));
            check("R4 clear", {7'd0, irq_oe}, {7'd0, (c != 0)});
            check_req("R4 clear pattern");
        end

        // R5 set and clear collide
        step('0, 1'b1, 2'd2, 8'h00);
        step(8'h11, 1'b1, 2'd2, 8'h00);
        check_req("R5 set wins");
        check_line("R5 line");

        // R7 partial clear keeps line
        step('0, 1'b1, 2'd2, 8'h00);
        step(8'h30, 1'b0, 2'd0, '0);
        step('0, 1'b1, 2'd2, 8'hEF);
        check("R7 still asserted", {7'd0, irq_oe}, 8'h01);
        check_line("R7 line");
        step('0, 1'b1, 2'd2, 8'hDF);
        check("R7 released", {7'd0, irq_oe}, 8'h00);

        // R8 raw read under full mask
        step(8'hA5, 1'b1, 2'd1, 8'hFF);
        check_req("R8 raw read");
        check_line("R8 line masked");
        rd(2'd1, v); check("R8 mask read", v, 8'hFF);

        // R6 random events, masks, enables and clears
        for (int k = 0; k < 3000; k++) begin
            int op;
            logic [N-1:0] ev;
            op = $urandom_range(0, 9);
            ev = 8'($urandom) & 8'($urandom) & 8'($urandom);
            case (op)
                0, 1:    step(ev, 1'b1, 2'd1, 8'($urandom));
                2, 3, 4: step(ev, 1'b1, 2'd2, 8'($urandom) | 8'($urandom));
                5:       step(ev, 1'b1, 2'd3, 8'($urandom));
                default: step(ev, 1'b0, 2'd0, '0);
            endcase
            check_line("R6 random");
            if (k % 50 == 0) check_req("R6 random req");
        end

        // R1 mid-run reset with pending unmasked requests
        step('0, 1'b1, 2'd1, 8'h00);
        step(8'hF8, 1'b0, 2'd0, '0);
        do_reset();
        rd(2'd0, v); check("R1 rerun req", v, 8'h00);
        rd(2'd1, v); check("R1 rerun mask", v, 8'hFF);
        rd(2'd3, v); check("R1 rerun erren", v, 8'h00);
        check("R1 rerun irq", {7'd0, irq_n}, 8'h01);

        finish_run();
    end

endmodule